// File: doc/BRIEF.md
# Memory access watch unit

This block sits beside a processor's data bus and looks at every access as an address with read and write strobes and a tag that marks where the access came from. When an access from the processor lands inside a watched address window, the block raises a sticky event flag for that window and direction. Software uses these flags to catch stray accesses while debugging, or to detect and recover from faults in the field. Accesses tagged as coming from a DMA master are never checked.

There are six windows. Four have programmable inclusive start and end byte addresses. Two are fixed 128 KB windows in peripheral space starting at 0x4000_0000. Each fixed window is cut into 32 subregions of 4 KB, and each subregion has its own include bit. For each fixed window, two sticky status words record which subregions produced its write and read events. A flat register port holds the bounds, the include masks, an enable word with set and clear aliases, the event flags and the status words. Event flags are also driven straight out as one output per window and direction.

Detection is pipelined. The flag for an access can first be seen after the second rising clock edge that follows the access.

Top module: `mem_watch_unit`

## Requirements
- R1: After reset the enable word, the event flags, the subregion include masks and the subregion status words all read as zero, and evtRd and evtWr are zero.
- R2: Programmable window k (k=0..3) has its start address at register offset 0x10+8k and its end address at 0x14+8k. An access matches when start <= addr <= end, so both bounds match and the addresses one below start and one above end do not.
- R3: Each window has a read event (evtRd[i] and event register bit i) and a write event (evtWr[i] and event register bit 8+i). A read sets only the read event and a write sets only the write event. Window indices are 0..3 for the programmable windows and 4..5 for fixed windows 0 and 1.
- R4: Fixed window 0 covers 0x4000_0000 to 0x4001_FFFF and fixed window 1 covers 0x4002_0000 to 0x4003_FFFF. The subregion index is the offset within the window, bits [16:12]. Include masks sit at offsets 0x30 and 0x34.
- R5: An access to a subregion whose include bit is zero raises no event and sets no status bit.
- R6: The enable word at offset 0x00 has read enable for window i in bit i and write enable in bit 8+i. A write to 0x04 ORs the written ones into it. A write to 0x08 clears the bits written as one. A single write can change several windows.
- R7: The event register at offset 0x0C is sticky. A register write clears exactly the flags whose bit is written as zero. Flags written as one are left unchanged.
- R8: For fixed window j, the write status sits at 0x38+8j and the read status at 0x3C+8j. A status bit is set when its subregion causes the matching event, stays set, and clears when software writes a one to it.
- R9: An access presented before rising edge n sets its flag after edge n+1. The flag is still clear between edges n and n+1.
- R10: An access with accCpu low (DMA-tagged) never raises an event.
- R11: A window whose read or write enable bit is clear raises no event of that direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| accAddr | input | 32 | Bus access byte address |
| accRd | input | 1 | Read strobe, one cycle per access |
| accWr | input | 1 | Write strobe, one cycle per access |
| accCpu | input | 1 | High when the access comes from the processor |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 8 | Register byte offset |
| cfgWdata | input | 32 | Register write data |
| cfgRdata | output | 32 | Register read data for cfgAddr (combinational) |
| evtRd | output | 6 | Sticky read event flag per window |
| evtWr | output | 6 | Sticky write event flag per window |

## Verification
The bench probes both programmable bounds and the bytes just outside them, using a single-byte window as well as a wider one. A comparator built with a strict inequality would miss the edge bytes, and one built off by one would flag a neighbouring byte. For the fixed windows it checks a subregion that is included next to one that is excluded, at low and high indices. A wrong index slice would set the wrong status bit, or fire on the excluded 4 KB block. It also samples between the two edges of the detection pipeline, so a design with too few or too many stages is caught. Finally it checks partial clears through the set and clear aliases, the zero-to-clear event register and the one-to-clear status words, because an alias that overwrites instead of merging changes bits that were never named in the write.

// File: rtl/mwu_pkg.sv
package mwu_pkg;
  localparam int ADDR_W    = 32;
  localparam int DATA_W    = 32;
  localparam int CFG_AW    = 8;
  localparam int NUM_CFG   = 4;
  localparam int NUM_FIX   = 2;
  localparam int NUM_RGN   = NUM_CFG + NUM_FIX;
  localparam int SUB_CNT   = 32;
  localparam int SUB_LSB   = 12;
  localparam int SUB_IDX_W = $clog2(SUB_CNT);
  localparam int EN_W      = 16;
  localparam int WR_OFS    = 8;
  localparam logic [ADDR_W-1:0] FIX_BASE = 32'h4000_0000;
  localparam logic [ADDR_W-1:0] FIX_SPAN = ADDR_W'(SUB_CNT) << SUB_LSB;

  localparam logic [CFG_AW-1:0] OFS_EN     = 8'h00;
  localparam logic [CFG_AW-1:0] OFS_SET    = 8'h04;
  localparam logic [CFG_AW-1:0] OFS_CLR    = 8'h08;
  localparam logic [CFG_AW-1:0] OFS_EVT    = 8'h0C;
  localparam int                OFS_START  = 'h10;
  localparam int                OFS_END    = 'h14;
  localparam int                OFS_SUBINC = 'h30;
  localparam int                OFS_STWR   = 'h38;
  localparam int                OFS_STRD   = 'h3C;

  typedef struct packed {
    logic [NUM_RGN-1:0]              rdHit;
    logic [NUM_RGN-1:0]              wrHit;
    logic [NUM_FIX-1:0][SUB_CNT-1:0] subRd;
    logic [NUM_FIX-1:0][SUB_CNT-1:0] subWr;
  } hit_t;
endpackage

// File: rtl/mwu_datapath.sv
module mwu_datapath
  import mwu_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [ADDR_W-1:0]                 accAddr,
  input  logic                              accRd,
  input  logic                              accWr,
  input  logic                              accCpu,
  input  logic [NUM_CFG-1:0][ADDR_W-1:0]    startAddr,
  input  logic [NUM_CFG-1:0][ADDR_W-1:0]    endAddr,
  input  logic [EN_W-1:0]                   enWord,
  input  logic [NUM_FIX-1:0][SUB_CNT-1:0]   subInc,
  output hit_t                              hits
);
  logic [ADDR_W-1:0]               addrQ;
  logic                            rdQ, wrQ;
  logic [NUM_RGN-1:0]              rgnMatch;
  logic [NUM_FIX-1:0][SUB_CNT-1:0] subSel;
  logic [NUM_RGN-1:0]              rdEn, wrEn;

  assign rdEn = enWord[NUM_RGN-1:0];
  assign wrEn = enWord[WR_OFS +: NUM_RGN];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      rdQ   <= 1'b0;
      wrQ   <= 1'b0;
    end else begin
      addrQ <= accAddr;
      rdQ   <= accRd & accCpu;
      wrQ   <= accWr & accCpu;
    end
  end

  for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
    assign rgnMatch[k] = (addrQ >= startAddr[k]) && (addrQ <= endAddr[k]);
  end

  for (genvar j = 0; j < NUM_FIX; j++) begin : g_fix
    logic [ADDR_W-1:0]    fixOfs;
    logic                 inFix;
    logic [SUB_IDX_W-1:0] subIdx;
    assign fixOfs = addrQ - (FIX_BASE + ADDR_W'(j) * FIX_SPAN);
    assign inFix  = fixOfs < FIX_SPAN;
    assign subIdx = fixOfs[SUB_LSB +: SUB_IDX_W];
    assign subSel[j] = inFix ? (subInc[j] & (SUB_CNT'(1) << subIdx)) : '0;
    assign rgnMatch[NUM_CFG+j] = |subSel[j];
  end

  always_comb begin
    hits.rdHit = rgnMatch & rdEn & {NUM_RGN{rdQ}};
    hits.wrHit = rgnMatch & wrEn & {NUM_RGN{wrQ}};
    for (int j = 0; j < NUM_FIX; j++) begin
      hits.subRd[j] = (rdQ && rdEn[NUM_CFG+j]) ? subSel[j] : '0;
      hits.subWr[j] = (wrQ && wrEn[NUM_CFG+j]) ? subSel[j] : '0;
    end
  end
endmodule

// File: rtl/mwu_ctrl.sv
module mwu_ctrl
  import mwu_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             cfgWe,
  input  logic [CFG_AW-1:0]                cfgAddr,
  input  logic [DATA_W-1:0]                cfgWdata,
  input  hit_t                             hits,
  output logic [DATA_W-1:0]                cfgRdata,
  output logic [EN_W-1:0]                  enWord,
  output logic [NUM_CFG-1:0][ADDR_W-1:0]   startAddr,
  output logic [NUM_CFG-1:0][ADDR_W-1:0]   endAddr,
  output logic [NUM_FIX-1:0][SUB_CNT-1:0]  subInc,
  output logic [NUM_RGN-1:0]               evtRd,
  output logic [NUM_RGN-1:0]               evtWr,
  output logic [NUM_FIX-1:0][SUB_CNT-1:0]  stRd,
  output logic [NUM_FIX-1:0][SUB_CNT-1:0]  stWr
);
  logic evtWrite;
  assign evtWrite = cfgWe && (cfgAddr == OFS_EVT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enWord    <= '0;
      startAddr <= '0;
      endAddr   <= '0;
      subInc    <= '0;
      evtRd     <= '0;
      evtWr     <= '0;
      stRd      <= '0;
      stWr      <= '0;
    end else begin
      if (cfgWe) begin
        case (cfgAddr)
          OFS_EN:  enWord <= cfgWdata[EN_W-1:0];
          OFS_SET: enWord <= enWord | cfgWdata[EN_W-1:0];
          OFS_CLR: enWord <= enWord & ~cfgWdata[EN_W-1:0];
          default: ;
        endcase
      end
      for (int k = 0; k < NUM_CFG; k++) begin
        if (cfgWe && cfgAddr == CFG_AW'(OFS_START + 8*k)) startAddr[k] <= cfgWdata;
        if (cfgWe && cfgAddr == CFG_AW'(OFS_END + 8*k))   endAddr[k]   <= cfgWdata;
      end
      evtRd <= (evtWrite ? (evtRd & cfgWdata[NUM_RGN-1:0]) : evtRd) | hits.rdHit;
      evtWr <= (evtWrite ? (evtWr & cfgWdata[WR_OFS +: NUM_RGN]) : evtWr) | hits.wrHit;
      for (int j = 0; j < NUM_FIX; j++) begin
        if (cfgWe && cfgAddr == CFG_AW'(OFS_SUBINC + 4*j)) subInc[j] <= cfgWdata;
        stWr[j] <= ((cfgWe && cfgAddr == CFG_AW'(OFS_STWR + 8*j)) ? (stWr[j] & ~cfgWdata) : stWr[j])
                   | hits.subWr[j];
        stRd[j] <= ((cfgWe && cfgAddr == CFG_AW'(OFS_STRD + 8*j)) ? (stRd[j] & ~cfgWdata) : stRd[j])
                   | hits.subRd[j];
      end
    end
  end

  always_comb begin
    cfgRdata = '0;
    case (cfgAddr)
      OFS_EN:  cfgRdata = DATA_W'(enWord);
      OFS_EVT: begin
        cfgRdata[NUM_RGN-1:0]      = evtRd;
        cfgRdata[WR_OFS +: NUM_RGN] = evtWr;
      end
      default: ;
    endcase
    for (int k = 0; k < NUM_CFG; k++) begin
      if (cfgAddr == CFG_AW'(OFS_START + 8*k)) cfgRdata = startAddr[k];
      if (cfgAddr == CFG_AW'(OFS_END + 8*k))   cfgRdata = endAddr[k];
    end
    for (int j = 0; j < NUM_FIX; j++) begin
      if (cfgAddr == CFG_AW'(OFS_SUBINC + 4*j)) cfgRdata = subInc[j];
      if (cfgAddr == CFG_AW'(OFS_STWR + 8*j))   cfgRdata = stWr[j];
      if (cfgAddr == CFG_AW'(OFS_STRD + 8*j))   cfgRdata = stRd[j];
    end
  end
endmodule

// File: rtl/mem_watch_unit.sv
module mem_watch_unit
  import mwu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       accAddr,
  input  logic              accRd,
  input  logic              accWr,
  input  logic              accCpu,
  input  logic              cfgWe,
  input  logic [7:0]        cfgAddr,
  input  logic [31:0]       cfgWdata,
  output logic [31:0]       cfgRdata,
  output logic [5:0]        evtRd,
  output logic [5:0]        evtWr
);
  hit_t                            hits;
  logic [EN_W-1:0]                 enWord;
  logic [NUM_CFG-1:0][ADDR_W-1:0]  startAddr;
  logic [NUM_CFG-1:0][ADDR_W-1:0]  endAddr;
  logic [NUM_FIX-1:0][SUB_CNT-1:0] subInc;
  logic [NUM_FIX-1:0][SUB_CNT-1:0] stRd;
  logic [NUM_FIX-1:0][SUB_CNT-1:0] stWr;

  mwu_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .accAddr   (accAddr),
    .accRd     (accRd),
    .accWr     (accWr),
    .accCpu    (accCpu),
    .startAddr (startAddr),
    .endAddr   (endAddr),
    .enWord    (enWord),
    .subInc    (subInc),
    .hits      (hits)
  );

  mwu_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgAddr   (cfgAddr),
    .cfgWdata  (cfgWdata),
    .hits      (hits),
    .cfgRdata  (cfgRdata),
    .enWord    (enWord),
    .startAddr (startAddr),
    .endAddr   (endAddr),
    .subInc    (subInc),
    .evtRd     (evtRd),
    .evtWr     (evtWr),
    .stRd      (stRd),
    .stWr      (stWr)
  );
endmodule

// File: rtl/mwu_checker.sv
module mwu_checker
  import mwu_pkg::*;
(
  input logic                             clk,
  input logic                             rstN,
  input logic                             accRd,
  input logic                             accWr,
  input logic                             accCpu,
  input logic                             cfgWe,
  input logic [CFG_AW-1:0]                cfgAddr,
  input logic [DATA_W-1:0]                cfgWdata,
  input logic [NUM_RGN-1:0]               evtRd,
  input logic [NUM_RGN-1:0]               evtWr,
  input logic [EN_W-1:0]                  enWord,
  input logic [NUM_FIX-1:0][SUB_CNT-1:0]  subInc,
  input logic [NUM_FIX-1:0][SUB_CNT-1:0]  stRd,
  input logic [NUM_FIX-1:0][SUB_CNT-1:0]  stWr
);
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (|(evtRd & ~$past(evtRd))) |-> $past(accRd, 2)); // R9
  AST_WR_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (|(evtWr & ~$past(evtWr))) |-> $past(accWr, 2)); // R9
  AST_DMA_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (|((evtRd & ~$past(evtRd)) | (evtWr & ~$past(evtWr)))) |-> $past(accCpu, 2)); // R10
  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (|(($past(evtRd) & ~evtRd) | ($past(evtWr) & ~evtWr)))
      |-> $past(cfgWe && cfgAddr == OFS_EVT)); // R7
  AST_SET_MERGE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgAddr == OFS_SET)
      |=> ((enWord & $past(cfgWdata[EN_W-1:0])) == $past(cfgWdata[EN_W-1:0]))); // R6
  AST_CLR_MERGE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgAddr == OFS_CLR) |=> ((enWord & $past(cfgWdata[EN_W-1:0])) == '0)); // R6

  for (genvar j = 0; j < NUM_FIX; j++) begin : g_sub
    AST_EXCLUDED_RD: assert property (@(posedge clk) disable iff (!rstN)
      ((stRd[j] & ~$past(stRd[j]) & ~$past(subInc[j])) == '0)); // R5
    AST_EXCLUDED_WR: assert property (@(posedge clk) disable iff (!rstN)
      ((stWr[j] & ~$past(stWr[j]) & ~$past(subInc[j])) == '0)); // R5
  end
endmodule

bind mem_watch_unit mwu_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .accRd    (accRd),
  .accWr    (accWr),
  .accCpu   (accCpu),
  .cfgWe    (cfgWe),
  .cfgAddr  (cfgAddr),
  .cfgWdata (cfgWdata),
  .evtRd    (evtRd),
  .evtWr    (evtWr),
  .enWord   (enWord),
  .subInc   (subInc),
  .stRd     (stRd),
  .stWr     (stWr)
);

// File: tb/mem_watch_unit_tb.sv
`timescale 1ns/1ps
module mem_watch_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] accAddr = '0;
  logic        accRd = 1'b0, accWr = 1'b0, accCpu = 1'b0;
  logic        cfgWe = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic [5:0]  evtRd, evtWr;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mem_watch_unit u_dut (
    .clk(clk), .rstN(rstN), .accAddr(accAddr), .accRd(accRd), .accWr(accWr),
    .accCpu(accCpu), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .evtRd(evtRd), .evtWr(evtWr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0; cfgWdata = '0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    cfgAddr = a;
    #1 d = cfgRdata;
  endtask

  task automatic busAccess(input logic [31:0] a, input bit rd, input bit wr, input bit cpu);
    @(negedge clk);
    accAddr = a; accRd = rd; accWr = wr; accCpu = cpu;
    @(negedge clk);
    accRd = 1'b0; accWr = 1'b0; accCpu = 1'b0;
    @(negedge clk);
  endtask

  task automatic clearEvents();
    regWrite(8'h0C, 32'h0);
  endtask

  task automatic testReset();
    logic [31:0] d;
    chkEq("R1 evtRd", {26'b0, evtRd}, 32'h0);
    chkEq("R1 evtWr", {26'b0, evtWr}, 32'h0);
    regRead(8'h00, d); chkEq("R1 enable", d, 32'h0);
    regRead(8'h0C, d); chkEq("R1 events", d, 32'h0);
    regRead(8'h30, d); chkEq("R1 include0", d, 32'h0);
    regRead(8'h44, d); chkEq("R1 status rd1", d, 32'h0);
  endtask

  task automatic testEnableAliases();
    logic [31:0] d;
    regWrite(8'h04, 32'h0F03);
    regRead(8'h00, d); chkEq("R6 set", d, 32'h0F03);
    regWrite(8'h08, 32'h0102);
    regRead(8'h00, d); chkEq("R6 clr multi", d, 32'h0E01);
    regWrite(8'h04, 32'h3F3F);
    regRead(8'h00, d); chkEq("R6 set all", d, 32'h3F3F);
  endtask

  task automatic testBounds();
    logic [31:0] d;
    regWrite(8'h10, 32'h2000_0100);
    regWrite(8'h14, 32'h2000_01FF);
    // latency: flag clear after first edge, set after second (R9)
    @(negedge clk);
    accAddr = 32'h2000_0100; accRd = 1'b1; accCpu = 1'b1;
    @(negedge clk);
    accRd = 1'b0; accCpu = 1'b0;
    chkEq("R9 not yet", {26'b0, evtRd}, 32'h0);
    @(negedge clk);
    chkEq("R9 after two edges", {26'b0, evtRd}, 32'h1);
    chkEq("R2 start bound", {26'b0, evtRd}, 32'h1);
    clearEvents();
    busAccess(32'h2000_01FF, 1, 0, 1);
    chkEq("R2 end bound", {26'b0, evtRd}, 32'h1);
    clearEvents();
    busAccess(32'h2000_00FF, 1, 0, 1);
    busAccess(32'h2000_0200, 1, 0, 1);
    chkEq("R2 outside", {26'b0, evtRd}, 32'h0);
    busAccess(32'h2000_0150, 0, 1, 1);
    chkEq("R3 write sets wr", {26'b0, evtWr}, 32'h1);
    chkEq("R3 write leaves rd", {26'b0, evtRd}, 32'h0);
    regRead(8'h0C, d); chkEq("R3 event reg layout", d, 32'h0100);
    // single byte region 3
    regWrite(8'h28, 32'h2000_0400);
    regWrite(8'h2C, 32'h2000_0400);
    busAccess(32'h2000_0400, 1, 0, 1);
    chkEq("R2 single byte", {26'b0, evtRd}, 32'h8);
    busAccess(32'h2000_0401, 1, 0, 1);
    chkEq("R2 single byte neighbour", {26'b0, evtRd}, 32'h8);
  endtask

  task automatic testSticky();
    logic [31:0] d;
    regWrite(8'h0C, 32'hFFFF_FFFF);
    regRead(8'h0C, d); chkEq("R7 write ones keeps", d, 32'h0108);
    regWrite(8'h0C, 32'h0000_0008);
    regRead(8'h0C, d); chkEq("R7 partial clear", d, 32'h0008);
    clearEvents();
    regRead(8'h0C, d); chkEq("R7 full clear", d, 32'h0);
  endtask

  task automatic testDmaAndDisable();
    busAccess(32'h2000_0120, 1, 1, 0);
    chkEq("R10 dma rd", {26'b0, evtRd}, 32'h0);
    chkEq("R10 dma wr", {26'b0, evtWr}, 32'h0);
    regWrite(8'h08, 32'h0001);
    busAccess(32'h2000_0120, 1, 0, 1);
    chkEq("R11 read disabled", {26'b0, evtRd}, 32'h0);
    busAccess(32'h2000_0120, 0, 1, 1);
    chkEq("R11 write still enabled", {26'b0, evtWr}, 32'h1);
    regWrite(8'h04, 32'h0001);
    clearEvents();
  endtask

  task automatic testFixed();
    logic [31:0] d;
    regWrite(8'h30, 32'h0000_0020);
    busAccess(32'h4000_5010, 1, 0, 1);
    chkEq("R4 fixed0 sub5 event", {26'b0, evtRd}, 32'h10);
    regRead(8'h3C, d); chkEq("R8 status rd0", d, 32'h0000_0020);
    clearEvents();
    busAccess(32'h4000_6000, 1, 0, 1);
    chkEq("R5 excluded sub6 event", {26'b0, evtRd}, 32'h0);
    regRead(8'h3C, d); chkEq("R5 excluded sub6 status", d, 32'h0000_0020);
    busAccess(32'h4002_5010, 1, 0, 1);
    chkEq("R5 fixed1 sub5 excluded", {26'b0, evtRd}, 32'h0);
    regWrite(8'h34, 32'h8000_0000);
    busAccess(32'h4003_F000, 0, 1, 1);
    chkEq("R4 fixed1 sub31 event", {26'b0, evtWr}, 32'h20);
    regRead(8'h40, d); chkEq("R8 status wr1", d, 32'h8000_0000);
    regRead(8'h38, d); chkEq("R8 status wr0 untouched", d, 32'h0);
    regWrite(8'h3C, 32'h0000_0001);
    regRead(8'h3C, d); chkEq("R8 w1c other bit", d, 32'h0000_0020);
    regWrite(8'h40, 32'h8000_0000);
    regRead(8'h40, d); chkEq("R8 w1c clears", d, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEnableAliases();
    testBounds();
    testSticky();
    testDmaAndDisable();
    testFixed();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule